// File: doc/BRIEF.md
# Stacked register-pair file

This block is the register file of a small 8-bit processor. It keeps eight byte registers, F, T, B, C, D, E, H and L, which also pair up as four 16-bit registers: FT, BC, DE and HL. Behind every pair sits a private last-in, first-out store. The value a program sees in the pair is the top of that store. Pushing copies the visible value down into the store and leaves the register as it was. Popping brings the most recently saved value back into the register.

Each pair has its own push and pop strobe, so an interrupt handler can save or restore all four pairs in a single clock. The register side has two combinational read ports and one write port. Each port picks either one byte register by its 3-bit index or one pair by its 2-bit index. Nothing here is a stream: every access either completes in the cycle it is presented or is dropped by a priority rule. For that reason the interface has no valid/ready handshake, and every pin is plain control or data.

The store depth `STK_DEPTH` is a parameter and defaults to 256 entries per pair. The per-pair pointer counts modulo that depth.

Top module: `rps_regfile`

## Requirements
- R1: After reset all eight byte registers read 0, `stk_clash` is 0, and every stack pointer holds `STK_DEPTH-1`.
- R2: With a port's wide bit at 0, its 3-bit index selects a byte register in the order 0=F, 1=T, 2=B, 3=C, 4=D, 5=E, 6=H, 7=L. A narrow read returns the byte in bits 7:0 with bits 15:8 at 0, and a narrow write takes `wr_data[7:0]` and changes only that byte.
- R3: With a port's wide bit at 1, index bits 1:0 select the pair 0=FT, 1=BC, 2=DE, 3=HL. The first-named register of the pair is bits 15:8.
- R4: A write is visible on the read ports in the cycle after the clock edge that accepts it. A wide write replaces both bytes of the pair.
- R5: A push on a pair stores the pair's current value at the entry below the pointer and decrements the pointer. The visible pair value does not change.
- R6: A pop on a pair loads the pair from the entry at the pointer and increments the pointer, so the values come back in last-in, first-out order.
- R7: Push and pop strobes on different pairs act independently, including all four pairs pushing, or all four popping, in one cycle.
- R8: A write and a push to the same pair in one cycle store the old value on the stack and put the written value in the register.
- R9: Push and pop on the same pair in one cycle perform only the pop. The matching bit of `stk_clash` is 1 for exactly the one cycle after that edge.
- R10: A pop and a write to the same pair in one cycle perform the pop, and the write is discarded.
- R11: The stack pointers wrap modulo `STK_DEPTH` with no error indication. After `STK_DEPTH+1` pushes, the oldest entry has been overwritten by the newest.
- R12: The two read ports select and return data independently of each other in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_wide | input | 1 | Read port A: 1 selects a pair, 0 selects a byte |
| rd_a_sel | input | 3 | Read port A: register or pair index |
| rd_a_data | output | 16 | Read port A: data |
| rd_b_wide | input | 1 | Read port B: 1 selects a pair, 0 selects a byte |
| rd_b_sel | input | 3 | Read port B: register or pair index |
| rd_b_data | output | 16 | Read port B: data |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | Write width: 1 selects a pair, 0 selects a byte |
| wr_sel | input | 3 | Write register or pair index |
| wr_data | input | 16 | Write data; only bits 7:0 are used for a byte write |
| push | input | 4 | Per-pair push strobes, bit 0 = FT through bit 3 = HL |
| pop | input | 4 | Per-pair pop strobes, same bit order |
| stk_clash | output | 4 | Per-pair flag for a push and pop in the same cycle, registered |

## Verification
Two pairs of functions can land on one pair in the same cycle. The first is a register write with a push. The second is a pop together with either a push or a write. The vector table sets up these collisions on purpose. It first loads a known value, pushes it, and then overwrites the register, so that the value that comes back reveals which operation won. Each collision is judged by the pair's contents read through a port in the following cycle, and by whether `stk_clash` for that pair is raised for exactly one cycle.

// File: rtl/rps_pkg.sv
package rps_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned PAIR_W     = 2 * BYTE_W;
  localparam int unsigned NPAIRS     = 4;
  localparam int unsigned NREGS      = 2 * NPAIRS;
  localparam int unsigned REG_IDX_W  = $clog2(NREGS);
  localparam int unsigned PAIR_IDX_W = $clog2(NPAIRS);

  typedef logic [REG_IDX_W-1:0]  reg_idx_t;
  typedef logic [PAIR_IDX_W-1:0] pair_idx_t;
  typedef logic [PAIR_W-1:0]     pair_t;
  typedef logic [BYTE_W-1:0]     byte_t;

  // Even register index names the high byte of its pair.
  function automatic pair_idx_t pair_of(reg_idx_t r);
    return r[REG_IDX_W-1:1];
  endfunction

  function automatic logic is_high(reg_idx_t r);
    return ~r[0];
  endfunction
endpackage

// File: rtl/rps_pair_stack.sv
module rps_pair_stack
  import rps_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_i,
  input  logic  pop_i,
  input  pair_t top_i,
  output pair_t pop_data_o,
  output logic  clash_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  pair_t            mem [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_dn;
  logic [PTR_W-1:0] ptr_up;
  logic             do_push;
  logic             clash_q;

  // Pop wins over push on the same pair.
  assign do_push = push_i & ~pop_i;
  assign ptr_dn  = (ptr_q == '0) ? PTR_LAST : ptr_q - 1'b1;
  assign ptr_up  = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= PTR_LAST;
      clash_q <= 1'b0;
    end else begin
      clash_q <= push_i & pop_i;
      if (pop_i)        ptr_q <= ptr_up;
      else if (do_push) ptr_q <= ptr_dn;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[ptr_dn] <= top_i;
  end

  assign pop_data_o = mem[ptr_q];
  assign clash_o    = clash_q;
endmodule

// File: rtl/rps_pair_reg.sv
module rps_pair_reg
  import rps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_hi_i,
  input  logic  wr_lo_i,
  input  pair_t wr_val_i,
  input  logic  pop_i,
  input  pair_t pop_val_i,
  output pair_t q_o
);
  pair_t q;
  pair_t nxt;

  always_comb begin
    nxt = q;
    if (pop_i) begin
      nxt = pop_val_i;
    end else begin
      if (wr_hi_i) nxt[PAIR_W-1:BYTE_W] = wr_val_i[PAIR_W-1:BYTE_W];
      if (wr_lo_i) nxt[BYTE_W-1:0]      = wr_val_i[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/rps_read_port.sv
module rps_read_port
  import rps_pkg::*;
(
  input  logic                     wide_i,
  input  reg_idx_t                 sel_i,
  input  logic [NPAIRS*PAIR_W-1:0] pairs_i,
  output pair_t                    data_o
);
  pair_idx_t pidx;
  pair_t     pval;

  assign pidx = wide_i ? sel_i[PAIR_IDX_W-1:0] : pair_of(sel_i);
  assign pval = pairs_i[pidx*PAIR_W +: PAIR_W];

  always_comb begin
    if (wide_i)              data_o = pval;
    else if (is_high(sel_i)) data_o = {{BYTE_W{1'b0}}, pval[PAIR_W-1:BYTE_W]};
    else                     data_o = {{BYTE_W{1'b0}}, pval[BYTE_W-1:0]};
  end
endmodule

// File: rtl/rps_regfile.sv
module rps_regfile
  import rps_pkg::*;
#(
  parameter int unsigned STK_DEPTH = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_a_wide,
  input  logic [REG_IDX_W-1:0]  rd_a_sel,
  output logic [PAIR_W-1:0]     rd_a_data,
  input  logic                  rd_b_wide,
  input  logic [REG_IDX_W-1:0]  rd_b_sel,
  output logic [PAIR_W-1:0]     rd_b_data,
  input  logic                  wr_en,
  input  logic                  wr_wide,
  input  logic [REG_IDX_W-1:0]  wr_sel,
  input  logic [PAIR_W-1:0]     wr_data,
  input  logic [NPAIRS-1:0]     push,
  input  logic [NPAIRS-1:0]     pop,
  output logic [NPAIRS-1:0]     stk_clash
);
  logic [NPAIRS*PAIR_W-1:0] pair_flat;
  pair_idx_t                wr_pair;
  logic                     wr_hi_any;
  logic                     wr_lo_any;
  pair_t                    wr_val;

  assign wr_pair   = wr_wide ? wr_sel[PAIR_IDX_W-1:0] : pair_of(wr_sel);
  assign wr_hi_any = wr_en & (wr_wide | is_high(wr_sel));
  assign wr_lo_any = wr_en & (wr_wide | ~is_high(wr_sel));
  assign wr_val    = wr_wide ? wr_data : {wr_data[BYTE_W-1:0], wr_data[BYTE_W-1:0]};

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    logic  hit;
    pair_t cur;
    pair_t popv;

    assign hit = (wr_pair == pair_idx_t'(p));

    rps_pair_stack #(.DEPTH(STK_DEPTH)) u_stk (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push[p]),
      .pop_i      (pop[p]),
      .top_i      (cur),
      .pop_data_o (popv),
      .clash_o    (stk_clash[p])
    );

    rps_pair_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hi_i   (wr_hi_any & hit),
      .wr_lo_i   (wr_lo_any & hit),
      .wr_val_i  (wr_val),
      .pop_i     (pop[p]),
      .pop_val_i (popv),
      .q_o       (cur)
    );

    assign pair_flat[p*PAIR_W +: PAIR_W] = cur;
  end

  rps_read_port u_rd_a (
    .wide_i  (rd_a_wide),
    .sel_i   (rd_a_sel),
    .pairs_i (pair_flat),
    .data_o  (rd_a_data)
  );

  rps_read_port u_rd_b (
    .wide_i  (rd_b_wide),
    .sel_i   (rd_b_sel),
    .pairs_i (pair_flat),
    .data_o  (rd_b_data)
  );
endmodule

// File: rtl/rps_regfile_chk.sv
module rps_regfile_chk
  import rps_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_a_wide,
  input logic [REG_IDX_W-1:0]     rd_a_sel,
  input logic [PAIR_W-1:0]        rd_a_data,
  input logic                     wr_en,
  input logic                     wr_wide,
  input logic [REG_IDX_W-1:0]     wr_sel,
  input logic [PAIR_W-1:0]        wr_data,
  input logic [NPAIRS-1:0]        push,
  input logic [NPAIRS-1:0]        pop,
  input logic [NPAIRS-1:0]        stk_clash,
  input logic [NPAIRS*PAIR_W-1:0] pair_flat
);
  // R9
  clash_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stk_clash == $past(push & pop));

  // R3
  wide_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_wide |-> rd_a_data == pair_flat[rd_a_sel[PAIR_IDX_W-1:0]*PAIR_W +: PAIR_W]);

  // R2
  narrow_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_a_wide |-> rd_a_data[PAIR_W-1:BYTE_W] == '0);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pair_flat == '0 && stk_clash == '0));

  for (genvar i = 0; i < NPAIRS; i++) begin : g_chk
    logic hit;
    assign hit = wr_en && (wr_wide ? (wr_sel[PAIR_IDX_W-1:0] == i) : (wr_sel[REG_IDX_W-1:1] == i));

    // R5
    push_keeps_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push[i] && !pop[i] && !hit) |=> $stable(pair_flat[i*PAIR_W +: PAIR_W]));

    // R4
    wide_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr_wide && !pop[i]) |=> pair_flat[i*PAIR_W +: PAIR_W] == $past(wr_data));
  end
endmodule

bind rps_regfile rps_regfile_chk u_chk (.*);

// File: tb/sim_rps_regfile.sv
module sim_rps_regfile;
  import rps_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_a_wide = 1'b0, rd_b_wide = 1'b0;
  logic [2:0] rd_a_sel = '0, rd_b_sel = '0;
  logic [15:0] rd_a_data, rd_b_data;
  logic wr_en = 1'b0, wr_wide = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [3:0] push = '0, pop = '0;
  logic [3:0] stk_clash;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rps_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_wide(rd_a_wide), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_wide(rd_b_wide), .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
    .push(push), .pop(pop), .stk_clash(stk_clash)
  );

  typedef struct packed {
    logic        we;
    logic        ww;
    logic [2:0]  ws;
    logic [15:0] wd;
    logic [3:0]  pu;
    logic [3:0]  po;
    logic        aw;
    logic [2:0]  as;
    logic [15:0] ea;
    logic        bw;
    logic [2:0]  bs;
    logic [15:0] eb;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,3'd0,16'h1234,4'h0,4'h0, 1'b1,3'd0,16'h1234, 1'b0,3'd0,16'h0012, 4'd3},  // R3 FT wide write
    '{1'b1,1'b0,3'd1,16'h00AB,4'h0,4'h0, 1'b1,3'd0,16'h12AB, 1'b0,3'd1,16'h00AB, 4'd2},  // R2 T byte
    '{1'b1,1'b1,3'd1,16'h5566,4'h0,4'h0, 1'b0,3'd2,16'h0055, 1'b0,3'd3,16'h0066, 4'd4},  // R4 BC
    '{1'b1,1'b0,3'd6,16'h00CD,4'h0,4'h0, 1'b1,3'd3,16'hCD00, 1'b0,3'd7,16'h0000, 4'd2},  // R2 H byte
    '{1'b0,1'b0,3'd0,16'h0000,4'h1,4'h0, 1'b1,3'd0,16'h12AB, 1'b1,3'd1,16'h5566, 4'd5},  // R5 push FT
    '{1'b1,1'b1,3'd0,16'h9999,4'h0,4'h0, 1'b1,3'd0,16'h9999, 1'b0,3'd0,16'h0099, 4'd4},  // R4
    '{1'b0,1'b0,3'd0,16'h0000,4'h0,4'h1, 1'b1,3'd0,16'h12AB, 1'b0,3'd1,16'h00AB, 4'd6},  // R6 pop FT
    '{1'b1,1'b1,3'd0,16'h4444,4'h1,4'h0, 1'b1,3'd0,16'h4444, 1'b0,3'd0,16'h0044, 4'd8},  // R8 write+push
    '{1'b0,1'b0,3'd0,16'h0000,4'h0,4'h1, 1'b1,3'd0,16'h12AB, 1'b0,3'd0,16'h0012, 4'd8},  // R8 old value stacked
    '{1'b1,1'b1,3'd2,16'h7777,4'h0,4'h0, 1'b1,3'd2,16'h7777, 1'b0,3'd4,16'h0077, 4'd4},
    '{1'b1,1'b1,3'd3,16'h8888,4'h0,4'h0, 1'b1,3'd3,16'h8888, 1'b0,3'd6,16'h0088, 4'd4},
    '{1'b0,1'b0,3'd0,16'h0000,4'hF,4'h0, 1'b1,3'd2,16'h7777, 1'b1,3'd3,16'h8888, 4'd7},  // R7 push all
    '{1'b1,1'b1,3'd2,16'h0000,4'h0,4'h0, 1'b1,3'd2,16'h0000, 1'b1,3'd1,16'h5566, 4'd12}, // R12
    '{1'b1,1'b0,3'd7,16'h0011,4'h0,4'h0, 1'b1,3'd3,16'h8811, 1'b0,3'd7,16'h0011, 4'd2},  // R2 L byte
    '{1'b1,1'b1,3'd1,16'h0000,4'h0,4'h0, 1'b1,3'd1,16'h0000, 1'b0,3'd2,16'h0000, 4'd4},
    '{1'b0,1'b0,3'd0,16'h0000,4'h0,4'hF, 1'b1,3'd2,16'h7777, 1'b1,3'd3,16'h8888, 4'd7},  // R7 pop all
    '{1'b0,1'b0,3'd0,16'h0000,4'h0,4'h0, 1'b1,3'd0,16'h12AB, 1'b1,3'd1,16'h5566, 4'd7},
    '{1'b0,1'b0,3'd0,16'h0000,4'h1,4'h0, 1'b1,3'd0,16'h12AB, 1'b0,3'd1,16'h00AB, 4'd5},
    '{1'b1,1'b1,3'd0,16'h3333,4'h0,4'h0, 1'b1,3'd0,16'h3333, 1'b0,3'd0,16'h0033, 4'd4},
    '{1'b0,1'b0,3'd0,16'h0000,4'h1,4'h1, 1'b1,3'd0,16'h12AB, 1'b0,3'd0,16'h0012, 4'd9},  // R9 clash
    '{1'b0,1'b0,3'd0,16'h0000,4'h1,4'h0, 1'b1,3'd0,16'h12AB, 1'b1,3'd2,16'h7777, 4'd5},
    '{1'b1,1'b1,3'd0,16'h5555,4'h0,4'h1, 1'b1,3'd0,16'h12AB, 1'b0,3'd1,16'h00AB, 4'd10}  // R10 pop beats write
  };

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic ww, input logic [2:0] ws, input logic [15:0] wd,
                     input logic [3:0] pu, input logic [3:0] po);
    @(negedge clk);
    wr_en = we; wr_wide = ww; wr_sel = ws; wr_data = wd; push = pu; pop = po;
    @(negedge clk);
    wr_en = 1'b0; push = '0; pop = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state through both ports
    for (int r = 0; r < 8; r++) begin
      rd_a_wide = 1'b0; rd_a_sel = 3'(r);
      rd_b_wide = 1'b1; rd_b_sel = 3'(r % 4);
      #1;
      check("R1", "reset byte", rd_a_data, 16'h0000);
      check("R1", "reset pair", rd_b_data, 16'h0000);
    end
    check("R1", "reset clash", {12'h000, stk_clash}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].rq);
      @(negedge clk);
      wr_en = VECS[i].we; wr_wide = VECS[i].ww; wr_sel = VECS[i].ws; wr_data = VECS[i].wd;
      push = VECS[i].pu; pop = VECS[i].po;
      rd_a_wide = VECS[i].aw; rd_a_sel = VECS[i].as;
      rd_b_wide = VECS[i].bw; rd_b_sel = VECS[i].bs;
      @(negedge clk);
      wr_en = 1'b0; push = '0; pop = '0;
      #1;
      check(rq, $sformatf("vec %0d port A", i), rd_a_data, VECS[i].ea);
      check(rq, $sformatf("vec %0d port B", i), rd_b_data, VECS[i].eb);
      // R9: clash flag tracks same-pair push+pop for one cycle only
      check("R9", $sformatf("vec %0d clash", i), {12'h000, stk_clash}, {12'h000, VECS[i].pu & VECS[i].po});
    end

    // R11: wrap of the HL pointer after one more push than the depth
    rd_a_wide = 1'b1; rd_a_sel = 3'd3;
    for (int k = 0; k <= 256; k++) begin
      cyc(1'b1, 1'b1, 3'd3, 16'(k), 4'h0, 4'h0);
      cyc(1'b0, 1'b0, 3'd0, 16'h0000, 4'h8, 4'h0);
    end
    for (int j = 0; j <= 256; j++) begin
      cyc(1'b0, 1'b0, 3'd0, 16'h0000, 4'h0, 4'h8);
      #1;
      check(j == 256 ? "R11" : "R6", $sformatf("wrap pop %0d", j), rd_a_data,
            (j == 256) ? 16'd256 : 16'(256 - j));
    end
    check("R11", "no clash on wrap", {12'h000, stk_clash}, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule